// File: doc/BRIEF.md
# Serial EEPROM Image Loader with Checksum Gate

This block fetches a configuration image from a three-wire serial EEPROM (chip select, shift clock, data toward the part, data from the part) and releases a 48-bit station address only if the image passes a word-sum check. It starts on its own when reset is released. It starts again on a one-cycle `start` pulse once the previous pass has finished.

Each pass first works out how wide the part's word address is. It reads word 0 with a short address. If that read returns all ones, the part is taken to have long addresses. The block then reads every word of the image in ascending order and adds the words modulo 2^16. It compares the total against a fixed magic value. The first three words are kept and form the station address, which appears on the output only when the check has passed.

The shift clock comes from the system clock through a parameterized divider. Every high phase and every low phase of the shift clock lasts at least one divider period.

Top module: `mw_eeprom_loader`

## Requirements
- R1: A pass begins by itself after reset and again on a `start` pulse while the block is idle. A `start` pulse during a pass is ignored, and the pass completes with the same result and the same number of accesses.
- R2: `ee_di` changes only while `ee_sk` is low. `ee_sk` is low whenever `ee_cs` is low. Each high and each low phase of `ee_sk` lasts at least `CLK_DIV` system cycles.
- R3: Each access sends the 3-bit read opcode 1,1,0 and then the word address, most significant bit first, one bit per `ee_sk` rising edge. The addresses go out in this order: the probe of word 0, then words 0, 1, … up to `WORDS`-1.
- R4: After the address, 16 data bits are clocked in most significant bit first. Each bit is sampled from `ee_do` after the rising edge that presents it.
- R5: The probe read of word 0 uses a 6-bit address. A result of 0xFFFF selects 8-bit addresses for the rest of the pass. Any other result selects 6-bit addresses.
- R6: The `WORDS` (64) words are summed modulo 2^16. `valid` rises only if the sum equals `MAGIC` (0xBABA).
- R7: `station_addr[15:0]` = word 0, `[31:16]` = word 1 and `[47:32]` = word 2. Byte k of the address sits in bits [8k+7:8k], so the low byte of each word comes first.
- R8: Whenever `valid` is low, `station_addr` is all zeros. This covers a failed checksum and a pass still in progress.
- R9: `done` is high for exactly one cycle at the end of a pass. `valid` then holds its value until the next accepted start, which clears it.
- R10: Every access is framed separately. `ee_cs` goes low, then high, and drops low again after the 16th data bit, so a pass makes exactly `WORDS`+1 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a new pass when idle |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial command and address toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| done | output | 1 | One-cycle pulse when a pass completes |
| valid | output | 1 | Image checksum matched; holds until next start |
| station_addr | output | 48 | Station address, zero unless valid |

## Verification
A wrong address width or a damaged command shift register shows up within the first access. The serial-part model then receives a bad opcode or an out-of-order address, or it starts driving data at the wrong clock edge. That last fault corrupts the station address and the sum at the `done` pulse. A sum accumulator or word-capture fault stays hidden until `done`, and appears there as a wrong `valid` or a wrong `station_addr`. A framing or divider fault is caught on the pin activity itself: a data change during a high clock, a short clock phase, or an access count other than 65.

// File: rtl/mw_pkg.sv
package mw_pkg;
   localparam logic [2:0] READ_OPCODE = 3'b110;

   typedef enum logic [2:0] {
      E_IDLE, E_DESEL, E_SEL, E_CMD_LO, E_CMD_HI, E_DAT_LO, E_DAT_HI, E_END
   } eng_state_t;

   typedef enum logic [2:0] {
      S_IDLE, S_PROBE_REQ, S_PROBE_WAIT, S_READ_REQ, S_READ_WAIT
   } seq_state_t;
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/mw_shift_engine.sv
module mw_shift_engine
   import mw_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int SHORT_AW = 6,
   parameter int LONG_AW  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               req,
   input  logic               long_aw,
   input  logic [LONG_AW-1:0] addr,
   output logic               busy,
   output logic               word_done,
   output logic [WORD_W-1:0]  rdata,
   output logic               cs,
   output logic               sk,
   output logic               di,
   input  logic               do_i
);
   localparam int CMD_W  = 3 + LONG_AW;
   localparam int CMD_S  = 3 + SHORT_AW;
   localparam int MAXB   = (CMD_W > WORD_W) ? CMD_W : WORD_W;
   localparam int BW     = $clog2(MAXB + 1);
   localparam logic [BW-1:0] DATA_LAST = BW'(WORD_W - 1);

   eng_state_t        state_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [BW-1:0]     nbits_q;
   logic [BW-1:0]     cnt_q;
   logic [WORD_W-1:0] data_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= E_IDLE;
         cmd_q   <= '0;
         nbits_q <= '0;
         cnt_q   <= '0;
         data_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state_q == E_IDLE) begin
            if (req) begin
               cmd_q   <= long_aw ? {READ_OPCODE, addr}
                                  : {READ_OPCODE, addr[SHORT_AW-1:0], {(LONG_AW-SHORT_AW){1'b0}}};
               nbits_q <= long_aw ? BW'(CMD_W) : BW'(CMD_S);
               cnt_q   <= '0;
               state_q <= E_DESEL;
            end
         end else if (tick) begin
            case (state_q)
               E_DESEL:  state_q <= E_SEL;
               E_SEL:    state_q <= E_CMD_LO;
               E_CMD_LO: state_q <= E_CMD_HI;
               E_CMD_HI: begin
                  cmd_q <= cmd_q << 1;
                  if (cnt_q == nbits_q - 1'b1) begin
                     cnt_q   <= '0;
                     state_q <= E_DAT_LO;
                  end else begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= E_CMD_LO;
                  end
               end
               E_DAT_LO: state_q <= E_DAT_HI;
               E_DAT_HI: begin
                  data_q <= {data_q[WORD_W-2:0], do_i};
                  if (cnt_q == DATA_LAST) begin
                     cnt_q   <= '0;
                     state_q <= E_END;
                  end else begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= E_DAT_LO;
                  end
               end
               E_END: begin
                  done_q  <= 1'b1;
                  state_q <= E_IDLE;
               end
               default: state_q <= E_IDLE;
            endcase
         end
      end
   end

   assign busy      = (state_q != E_IDLE);
   assign word_done = done_q;
   assign rdata     = data_q;
   assign cs        = (state_q == E_SEL) || (state_q == E_CMD_LO) || (state_q == E_CMD_HI)
                   || (state_q == E_DAT_LO) || (state_q == E_DAT_HI);
   assign sk        = (state_q == E_CMD_HI) || (state_q == E_DAT_HI);
   assign di        = ((state_q == E_CMD_LO) || (state_q == E_CMD_HI)) && cmd_q[CMD_W-1];
endmodule

// File: rtl/mw_eeprom_loader.sv
module mw_eeprom_loader
   import mw_pkg::*;
#(
   parameter int          CLK_DIV   = 4,
   parameter int          WORD_W    = 16,
   parameter int          WORDS     = 64,
   parameter int          SHORT_AW  = 6,
   parameter int          LONG_AW   = 8,
   parameter int          MAC_WORDS = 3,
   parameter logic [15:0] MAGIC     = 16'hBABA
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   output logic                          ee_cs,
   output logic                          ee_sk,
   output logic                          ee_di,
   input  logic                          ee_do,
   output logic                          done,
   output logic                          valid,
   output logic [MAC_WORDS*WORD_W-1:0]   station_addr
);
   localparam int IDX_W = $clog2(WORDS);
   localparam int MAC_W = MAC_WORDS * WORD_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   initial begin
      assert (CLK_DIV >= 1)                else $error("CLK_DIV must be at least 1");
      assert (SHORT_AW < LONG_AW)          else $error("short address must be narrower");
      assert (WORDS <= (1 << SHORT_AW))    else $error("image must fit short addressing");
      assert (MAC_WORDS <= WORDS)          else $error("address words exceed image");
      assert (WORD_W == 16)                else $error("word width fixed at 16 by the sum");
   end

   logic              tick;
   logic              eng_req, eng_busy, eng_done;
   logic              eng_long;
   logic [LONG_AW-1:0] eng_addr;
   logic [WORD_W-1:0] eng_data;

   seq_state_t        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic              long_q;
   logic [WORD_W-1:0] sum_q;
   logic [MAC_W-1:0]  mac_q;
   logic              done_q, valid_q;
   logic [WORD_W-1:0] sum_nx;

   mw_tick_gen #(.DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   mw_shift_engine #(.WORD_W(WORD_W), .SHORT_AW(SHORT_AW), .LONG_AW(LONG_AW)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .req(eng_req), .long_aw(eng_long), .addr(eng_addr),
      .busy(eng_busy), .word_done(eng_done), .rdata(eng_data),
      .cs(ee_cs), .sk(ee_sk), .di(ee_di), .do_i(ee_do)
   );

   assign eng_req  = ((state_q == S_PROBE_REQ) || (state_q == S_READ_REQ)) && !eng_busy;
   assign eng_long = (state_q == S_READ_REQ) && long_q;
   assign eng_addr = (state_q == S_READ_REQ) ? LONG_AW'(idx_q) : '0;
   assign sum_nx   = sum_q + eng_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_PROBE_REQ;
         idx_q   <= '0;
         long_q  <= 1'b0;
         sum_q   <= '0;
         mac_q   <= '0;
         done_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: if (start) begin
               idx_q   <= '0;
               long_q  <= 1'b0;
               sum_q   <= '0;
               valid_q <= 1'b0;
               state_q <= S_PROBE_REQ;
            end
            S_PROBE_REQ: if (eng_req) state_q <= S_PROBE_WAIT;
            S_PROBE_WAIT: if (eng_done) begin
               long_q  <= (eng_data == '1);
               state_q <= S_READ_REQ;
            end
            S_READ_REQ: if (eng_req) state_q <= S_READ_WAIT;
            S_READ_WAIT: if (eng_done) begin
               sum_q <= sum_nx;
               if (int'(idx_q) < MAC_WORDS)
                  mac_q[int'(idx_q)*WORD_W +: WORD_W] <= eng_data;
               if (idx_q == LAST_IDX) begin
                  done_q  <= 1'b1;
                  valid_q <= (sum_nx == MAGIC);
                  state_q <= S_IDLE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= S_READ_REQ;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign done         = done_q;
   assign valid        = valid_q;
   assign station_addr = valid_q ? mac_q : '0;
endmodule

// File: rtl/mw_eeprom_loader_chk.sv
module mw_eeprom_loader_chk #(
   parameter int CLK_DIV = 4,
   parameter int ADDR_W  = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              ee_cs,
   input logic              ee_sk,
   input logic              ee_di,
   input logic              done,
   input logic              valid,
   input logic [ADDR_W-1:0] station_addr
);
   localparam int RW = $clog2(CLK_DIV + 1) + 1;
   logic          sk_q;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sk_q  <= 1'b0;
         run_q <= RW'(CLK_DIV);
      end else begin
         sk_q <= ee_sk;
         if (ee_sk != sk_q)              run_q <= RW'(1);
         else if (run_q < RW'(CLK_DIV))  run_q <= run_q + 1'b1;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                  // R9
   AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !start) |=> valid);                                     // R9
   AST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (station_addr == '0));                                 // R8
   AST_SK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_cs |-> !ee_sk);                                               // R2
   AST_DI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk && sk_q) |-> $stable(ee_di));                              // R2
   AST_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk != sk_q) |-> (run_q >= RW'(CLK_DIV)));                     // R2
endmodule

bind mw_eeprom_loader mw_eeprom_loader_chk #(.CLK_DIV(CLK_DIV), .ADDR_W(MAC_WORDS*WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .ee_cs(ee_cs), .ee_sk(ee_sk),
   .ee_di(ee_di), .done(done), .valid(valid), .station_addr(station_addr)
);

// File: tb/mw_eeprom_loader_test.sv
module mw_eeprom_loader_test;
   localparam int CLK_DIV = 2;
   localparam logic [15:0] MAGIC = 16'hBABA;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ee_do = 1'b1;
   logic ee_cs, ee_sk, ee_di, done, valid;
   logic [47:0] station_addr;

   int checks = 0, errors = 0;
   int acc_cnt = 0, proto_err = 0, order_err = 0;
   logic [15:0] mem [256];
   bit model_long = 1'b0;
   int bitcnt = 0, cur_addr = 0;
   logic [10:0] shreg = '0;

   always #5 clk = ~clk;

   mw_eeprom_loader #(.CLK_DIV(CLK_DIV)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ee_cs(ee_cs), .ee_sk(ee_sk),
      .ee_di(ee_di), .ee_do(ee_do), .done(done), .valid(valid), .station_addr(station_addr)
   );

   // serial EEPROM model: data bits appear after rising clock edges
   always @(posedge ee_cs) begin bitcnt = 0; acc_cnt++; ee_do = 1'b1; end
   always @(negedge ee_cs) ee_do = 1'b1;
   always @(posedge ee_sk) begin : model
      int nb, expa;
      logic [2:0] opc;
      if (ee_cs === 1'b1) begin
         nb = model_long ? 11 : 9;
         bitcnt++;
         if (bitcnt <= nb) begin
            shreg = {shreg[9:0], ee_di};
            if (bitcnt == nb) begin
               opc      = model_long ? shreg[10:8] : shreg[8:6];
               cur_addr = model_long ? int'(shreg[7:0]) : int'(shreg[5:0]);
               if (opc != 3'b110) proto_err++;
               expa = (acc_cnt <= 1) ? 0 : acc_cnt - 2;
               if (cur_addr != expa) order_err++;
            end
         end else if (bitcnt <= nb + 16) ee_do = mem[cur_addr][15 - (bitcnt - nb - 1)];
         else ee_do = 1'b1;
      end
   end

   // pin protocol monitor
   logic psk = 1'b0, pdi = 1'b0;
   int run = 0;
   always @(negedge clk) if (rst_n) begin
      if (ee_sk && psk && (ee_di != pdi)) proto_err++;
      if (!ee_cs && ee_sk) proto_err++;
      if (ee_sk != psk) begin
         if (ee_cs && run < CLK_DIV) proto_err++;
         run = 1;
      end else run++;
      psk = ee_sk;
      pdi = ee_di;
   end

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic load_image(input int seed, input bit long_part, input bit bad);
      logic [15:0] s = '0;
      model_long = long_part;
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h03B1 + seed * 16'h0111 + 16'h000F);
      if (long_part) mem[0] = 16'hFFFF;
      else if (mem[0] == 16'hFFFF) mem[0] = 16'h0001;
      for (int i = 0; i < 63; i++) s = s + mem[i];
      mem[63] = MAGIC - s + 16'(bad);
   endtask

   task automatic clear_counts();
      acc_cnt = 0; proto_err = 0; order_err = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic finish_pass(input bit exp_valid, input string tag);
      int n = 0;
      logic [47:0] exp_mac;
      exp_mac = exp_valid ? {mem[2], mem[1], mem[0]} : 48'h0;
      while (done !== 1'b1 && n < 30000) begin @(negedge clk); n++; end
      chk({"R9 done seen ", tag}, 64'(done), 64'd1);
      chk({"R6 valid ", tag}, 64'(valid), 64'(exp_valid));
      chk({"R7 R8 station address ", tag}, 64'(station_addr), 64'(exp_mac));
      @(negedge clk);
      chk({"R9 done one cycle ", tag}, 64'(done), 64'd0);
      repeat (40) @(negedge clk);
      chk({"R9 valid held ", tag}, 64'(valid), 64'(exp_valid));
      chk({"R10 access count ", tag}, 64'(acc_cnt), 64'd65);
      chk({"R2 R4 pin protocol ", tag}, 64'(proto_err), 64'd0);
      chk({"R3 address order ", tag}, 64'(order_err), 64'd0);
   endtask

   task automatic t_reset_and_auto();
      load_image(3, 1'b0, 1'b0);
      clear_counts();
      repeat (3) @(negedge clk);
      chk("R1 reset done", 64'(done), 64'd0);
      chk("R9 reset valid", 64'(valid), 64'd0);
      chk("R8 reset address", 64'(station_addr), 64'd0);
      chk("R10 reset cs", 64'(ee_cs), 64'd0);
      rst_n = 1'b1;
      finish_pass(1'b1, "short auto");
   endtask

   task automatic t_long_part();
      load_image(7, 1'b1, 1'b0);
      clear_counts();
      pulse_start();
      @(negedge clk);
      chk("R9 valid cleared by start", 64'(valid), 64'd0);
      finish_pass(1'b1, "long R5");
   endtask

   task automatic t_bad_sum();
      load_image(11, 1'b0, 1'b1);
      clear_counts();
      pulse_start();
      finish_pass(1'b0, "bad sum");
   endtask

   task automatic t_start_while_busy();
      load_image(21, 1'b0, 1'b0);
      clear_counts();
      pulse_start();
      repeat (1500) @(negedge clk);
      chk("R1 busy mid pass", 64'(done), 64'd0);
      pulse_start();
      finish_pass(1'b1, "R1 start ignored");
   endtask

   task automatic t_long_bad();
      load_image(5, 1'b1, 1'b1);
      clear_counts();
      pulse_start();
      finish_pass(1'b0, "long bad");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_and_auto();
      t_long_part();
      t_bad_sum();
      t_start_while_busy();
      t_long_bad();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule